// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register write path of a host-controlled storage controller. It watches every register write. Writes that land in the doorbell window are turned into pointer updates for paired queues. A submission queue has its tail pointer advanced by the host, and a completion queue has its head pointer released by the host. Each update is checked before it is applied. The queue number must be in range, the queue must exist, and the new pointer must be below the queue's size. A write that fails any check leaves every pointer and every trigger untouched.

Two trigger vectors leave the block, one bit per queue, and each pulse lasts a single cycle. An accepted tail write wakes the submission queue it names. An accepted head write on a completion queue that was full just before the write wakes the completion poster of that queue. The same write also wakes every existing submission queue bound to that queue. The completion tail comes in from the queue engine. The per-queue table, which holds existence, size and the submission-to-completion binding, is loaded through a configuration port.

Top module: `qdb_doorbell_decoder`

## Requirements
- R1: A write whose offset is below the window base (default 0x1000) changes no pointer and raises no trigger.
- R2: A write whose offset has either of its two lowest bits set changes no pointer and raises no trigger.
- R3: Inside the window, slot = (offset − base) / 4. An even slot is the tail doorbell of submission queue (offset − base) / 8. An odd slot is the head doorbell of completion queue (offset − base − 4) / 8. Queue 0 therefore uses base for its tail and base + 4 for its head.
- R4: Only data bits [15:0] form the new pointer, and the upper data bits are ignored.
- R5: A queue number equal to or above NUM_Q is ignored.
- R6: A doorbell for a queue whose existence flag is clear is ignored.
- R7: A new pointer equal to or above the size of the addressed queue is ignored.
- R8: An accepted tail write stores the pointer. In the next cycle, sq_kick has exactly the bit of that queue set.
- R9: An accepted head write stores the pointer. When the queue was not full, no trigger is raised.
- R10: A completion queue is full when (tail + 1) mod size equals head. An accepted head write on a full queue raises cq_kick for that queue in the next cycle. In the same cycle it raises sq_kick for every existing submission queue whose binding equals that queue.
- R11: After reset every pointer, flag and trigger is zero, and each trigger lasts exactly one cycle.
- R12: A configuration write (cfg_is_cq selects completion = 1 or submission = 0) loads the existence flag and size of queue cfg_qid. For a submission queue it also loads the binding. It clears that queue's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| cfg_en | input | 1 | Queue table configuration strobe |
| cfg_is_cq | input | 1 | 1 = completion entry, 0 = submission entry |
| cfg_qid | input | QID_W | Queue number configured |
| cfg_exists | input | 1 | Existence flag to load |
| cfg_size | input | 16 | Queue size in entries |
| cfg_bind | input | QID_W | Completion queue fed by a submission queue |
| cq_tail_i | input | NUM_Q*16 | Completion tails from the queue engine, queue q at bits [16q+15:16q] |
| sq_tail_o | output | NUM_Q*16 | Stored submission tails, same packing |
| cq_head_o | output | NUM_Q*16 | Stored completion heads, same packing |
| sq_kick | output | NUM_Q | Submission processing triggers |
| cq_kick | output | NUM_Q | Completion posting triggers |

## Verification
The bench aims at the slot parity. A decoder that mixed up even and odd slots, or took the queue number from the wrong shift, would move the partner pointer or wake the wrong queue. It also tries pointers exactly equal to the size, queue numbers one past the last queue, misaligned offsets just above the base, and data with busy upper bits. A design with a loose bound or a wide pointer would store a value that should be dropped. Completion tails are steered so that the queue is full about a third of the time. A design with a wrong fullness test or a wrong binding compare would either miss the wake-up burst or fire it on a non-full release.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int PTR_W = 16;
  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    DB_NONE    = 2'd0,
    DB_SQ_TAIL = 2'd1,
    DB_CQ_HEAD = 2'd2
  } db_kind_e;

  // Ring is full when advancing the producer would land on the consumer.
  function automatic logic ring_full(input ptr_t tail, input ptr_t head, input ptr_t size);
    logic [PTR_W:0] nxt;
    nxt = {1'b0, tail} + 1'b1;
    if (nxt >= {1'b0, size}) nxt = '0;
    return nxt[PTR_W-1:0] == head;
  endfunction

  function automatic logic ptr_in_range(input ptr_t ptr, input ptr_t size);
    return ptr < size;
  endfunction
endpackage

// File: rtl/qdb_addr_decode.sv
module qdb_addr_decode
  import qdb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_Q   = 8,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output db_kind_e          kind,
  output logic [QID_W-1:0]  qid,
  output logic              qid_ok,
  output logic              misaligned,
  output logic              in_window,
  output ptr_t              new_ptr
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-4:0] qid_full;
  logic [31-PTR_W:0] unused_hi;

  assign rel        = wr_addr - BASE;
  assign qid_full   = rel[ADDR_W-1:3];
  assign in_window  = wr_en && (wr_addr >= BASE);
  assign misaligned = wr_en && (wr_addr[1:0] != 2'b00);
  assign qid_ok     = ({1'b0, qid_full} < (ADDR_W-2)'(NUM_Q));
  assign qid        = qid_full[QID_W-1:0];
  assign new_ptr    = wr_data[PTR_W-1:0];
  assign unused_hi  = wr_data[31:PTR_W];

  always_comb begin
    kind = DB_NONE;
    if (in_window && !misaligned && (unused_hi == unused_hi))
      kind = rel[2] ? DB_CQ_HEAD : DB_SQ_TAIL;
  end
endmodule

// File: rtl/qdb_queue_table.sv
module qdb_queue_table
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 8,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_is_cq,
  input  logic [QID_W-1:0] cfg_qid,
  input  logic             cfg_exists,
  input  ptr_t             cfg_size,
  input  logic [QID_W-1:0] cfg_bind,
  input  logic             sq_upd,
  input  logic             cq_upd,
  input  logic [QID_W-1:0] upd_qid,
  input  ptr_t             upd_ptr,
  output logic             sq_exist [NUM_Q],
  output ptr_t             sq_size  [NUM_Q],
  output logic [QID_W-1:0] sq_bind  [NUM_Q],
  output ptr_t             sq_tail  [NUM_Q],
  output logic             cq_exist [NUM_Q],
  output ptr_t             cq_size  [NUM_Q],
  output ptr_t             cq_head  [NUM_Q]
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic cfg_sq_hit, cfg_cq_hit;
    assign cfg_sq_hit = cfg_en && !cfg_is_cq && (cfg_qid == QID_W'(q));
    assign cfg_cq_hit = cfg_en &&  cfg_is_cq && (cfg_qid == QID_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sq_exist[q] <= 1'b0;
        sq_size[q]  <= '0;
        sq_bind[q]  <= '0;
        sq_tail[q]  <= '0;
      end else if (cfg_sq_hit) begin
        sq_exist[q] <= cfg_exists;
        sq_size[q]  <= cfg_size;
        sq_bind[q]  <= cfg_bind;
        sq_tail[q]  <= '0;
      end else if (sq_upd && (upd_qid == QID_W'(q))) begin
        sq_tail[q]  <= upd_ptr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cq_exist[q] <= 1'b0;
        cq_size[q]  <= '0;
        cq_head[q]  <= '0;
      end else if (cfg_cq_hit) begin
        cq_exist[q] <= cfg_exists;
        cq_size[q]  <= cfg_size;
        cq_head[q]  <= '0;
      end else if (cq_upd && (upd_qid == QID_W'(q))) begin
        cq_head[q]  <= upd_ptr;
      end
    end
  end
endmodule

// File: rtl/qdb_kick_gen.sv
module qdb_kick_gen #(
  parameter int NUM_Q  = 8,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_upd,
  input  logic             cq_release_full,
  input  logic [QID_W-1:0] qid,
  input  logic             sq_exist [NUM_Q],
  input  logic [QID_W-1:0] sq_bind  [NUM_Q],
  output logic [NUM_Q-1:0] sq_kick,
  output logic [NUM_Q-1:0] cq_kick
);
  logic [NUM_Q-1:0] sq_nxt, cq_nxt;

  always_comb begin
    sq_nxt = '0;
    cq_nxt = '0;
    for (int s = 0; s < NUM_Q; s++) begin
      if (sq_upd && (qid == QID_W'(s)))
        sq_nxt[s] = 1'b1;
      if (cq_release_full && sq_exist[s] && (sq_bind[s] == qid))
        sq_nxt[s] = 1'b1;
      if (cq_release_full && (qid == QID_W'(s)))
        cq_nxt[s] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_kick <= '0;
      cq_kick <= '0;
    end else begin
      sq_kick <= sq_nxt;
      cq_kick <= cq_nxt;
    end
  end
endmodule

// File: rtl/qdb_doorbell_decoder.sv
module qdb_doorbell_decoder
  import qdb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_Q   = 8,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic                   cfg_en,
  input  logic                   cfg_is_cq,
  input  logic [QID_W-1:0]       cfg_qid,
  input  logic                   cfg_exists,
  input  logic [15:0]            cfg_size,
  input  logic [QID_W-1:0]       cfg_bind,
  input  logic [NUM_Q*16-1:0]    cq_tail_i,
  output logic [NUM_Q*16-1:0]    sq_tail_o,
  output logic [NUM_Q*16-1:0]    cq_head_o,
  output logic [NUM_Q-1:0]       sq_kick,
  output logic [NUM_Q-1:0]       cq_kick
);
  db_kind_e         dec_kind;
  logic [QID_W-1:0] dec_qid;
  logic             dec_qid_ok, dec_misaligned, dec_in_window;
  ptr_t             dec_ptr;

  logic             sq_exist [NUM_Q];
  ptr_t             sq_size  [NUM_Q];
  logic [QID_W-1:0] sq_bind  [NUM_Q];
  ptr_t             sq_tail  [NUM_Q];
  logic             cq_exist [NUM_Q];
  ptr_t             cq_size  [NUM_Q];
  ptr_t             cq_head  [NUM_Q];
  logic [NUM_Q-1:0] cq_full_vec;

  // Named events for the checker
  logic sq_upd, cq_upd, cq_was_full, cq_release_full;

  qdb_addr_decode #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .DB_BASE(DB_BASE)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .kind(dec_kind), .qid(dec_qid), .qid_ok(dec_qid_ok),
    .misaligned(dec_misaligned), .in_window(dec_in_window), .new_ptr(dec_ptr)
  );

  qdb_queue_table #(.NUM_Q(NUM_Q)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_is_cq(cfg_is_cq), .cfg_qid(cfg_qid),
    .cfg_exists(cfg_exists), .cfg_size(cfg_size), .cfg_bind(cfg_bind),
    .sq_upd(sq_upd), .cq_upd(cq_upd), .upd_qid(dec_qid), .upd_ptr(dec_ptr),
    .sq_exist(sq_exist), .sq_size(sq_size), .sq_bind(sq_bind), .sq_tail(sq_tail),
    .cq_exist(cq_exist), .cq_size(cq_size), .cq_head(cq_head)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_io
    assign sq_tail_o[q*16 +: 16] = sq_tail[q];
    assign cq_head_o[q*16 +: 16] = cq_head[q];
    assign cq_full_vec[q] = ring_full(cq_tail_i[q*16 +: 16], cq_head[q], cq_size[q]);
  end

  assign sq_upd = (dec_kind == DB_SQ_TAIL) && dec_qid_ok && sq_exist[dec_qid]
                  && ptr_in_range(dec_ptr, sq_size[dec_qid]);
  assign cq_upd = (dec_kind == DB_CQ_HEAD) && dec_qid_ok && cq_exist[dec_qid]
                  && ptr_in_range(dec_ptr, cq_size[dec_qid]);
  assign cq_was_full     = cq_full_vec[dec_qid];
  assign cq_release_full = cq_upd && cq_was_full;

  qdb_kick_gen #(.NUM_Q(NUM_Q)) u_kick (
    .clk(clk), .rst_n(rst_n),
    .sq_upd(sq_upd), .cq_release_full(cq_release_full), .qid(dec_qid),
    .sq_exist(sq_exist), .sq_bind(sq_bind),
    .sq_kick(sq_kick), .cq_kick(cq_kick)
  );
endmodule

// File: rtl/qdb_doorbell_checker.sv
module qdb_doorbell_checker #(
  parameter int NUM_Q = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                cfg_en,
  input logic                dec_misaligned,
  input logic                dec_in_window,
  input logic                dec_qid_ok,
  input logic                sq_upd,
  input logic                cq_upd,
  input logic                cq_release_full,
  input logic [NUM_Q*16-1:0] sq_tail_o,
  input logic [NUM_Q*16-1:0] cq_head_o,
  input logic [NUM_Q-1:0]    sq_kick,
  input logic [NUM_Q-1:0]    cq_kick
);
  p_unaligned_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_misaligned && !cfg_en) |=> ($stable(sq_tail_o) && $stable(cq_head_o)
                                     && sq_kick == '0 && cq_kick == '0));

  p_outside_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dec_in_window && !cfg_en) |=> ($stable(sq_tail_o) && $stable(cq_head_o)
                                              && sq_kick == '0));

  p_range_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_window && !dec_qid_ok && !cfg_en) |=> ($stable(sq_tail_o) && $stable(cq_head_o)
                                                    && cq_kick == '0 && sq_kick == '0));

  p_tail_kick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_upd |=> ($countones(sq_kick) == 1 && cq_kick == '0));

  p_cq_kick_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cq_kick));

  p_full_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cq_release_full |=> (cq_kick != '0));

  p_quiet_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_upd && !cq_release_full) |=> (sq_kick == '0 && cq_kick == '0));

  p_kick_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kick != '0) |-> $past(sq_upd || cq_release_full));
endmodule

bind qdb_doorbell_decoder qdb_doorbell_checker #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_en(cfg_en),
  .dec_misaligned(dec_misaligned), .dec_in_window(dec_in_window),
  .dec_qid_ok(dec_qid_ok), .sq_upd(sq_upd), .cq_upd(cq_upd),
  .cq_release_full(cq_release_full), .sq_tail_o(sq_tail_o),
  .cq_head_o(cq_head_o), .sq_kick(sq_kick), .cq_kick(cq_kick)
);

// File: tb/tb_qdb_doorbell_decoder.sv
`timescale 1ns/1ps
module tb_qdb_doorbell_decoder;
  localparam int NQ = 8;
  localparam int QW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cfg_en = 1'b0, cfg_is_cq = 1'b0, cfg_exists = 1'b0;
  logic [QW-1:0] cfg_qid = '0, cfg_bind = '0;
  logic [15:0] cfg_size = '0;
  logic [NQ*16-1:0] cq_tail_i, sq_tail_o, cq_head_o;
  logic [NQ-1:0] sq_kick, cq_kick;

  // Bench model
  logic        m_sx[NQ], m_cx[NQ];
  int          m_ss[NQ], m_cs[NQ], m_sb[NQ];
  int          m_st[NQ], m_ch[NQ];
  logic [15:0] m_ct[NQ];
  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NQ; i++) cq_tail_i[i*16 +: 16] = m_ct[i];

  qdb_doorbell_decoder #(.ADDR_W(16), .NUM_Q(NQ), .DB_BASE('h1000)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_en(cfg_en), .cfg_is_cq(cfg_is_cq), .cfg_qid(cfg_qid), .cfg_exists(cfg_exists),
    .cfg_size(cfg_size), .cfg_bind(cfg_bind), .cq_tail_i(cq_tail_i),
    .sq_tail_o(sq_tail_o), .cq_head_o(cq_head_o), .sq_kick(sq_kick), .cq_kick(cq_kick)
  );

  function automatic logic [NQ*16-1:0] pack_st();
    logic [NQ*16-1:0] v;
    for (int i = 0; i < NQ; i++) v[i*16 +: 16] = 16'(m_st[i]);
    return v;
  endfunction

  function automatic logic [NQ*16-1:0] pack_ch();
    logic [NQ*16-1:0] v;
    for (int i = 0; i < NQ; i++) v[i*16 +: 16] = 16'(m_ch[i]);
    return v;
  endfunction

  function automatic logic model_full(int q);
    return ((int'(m_ct[q]) + 1) % m_cs[q]) == m_ch[q];
  endfunction

  task automatic check_state(string tag, logic [NQ-1:0] eks, logic [NQ-1:0] ekc);
    n_checks++;
    if (sq_kick !== eks || cq_kick !== ekc || sq_tail_o !== pack_st() || cq_head_o !== pack_ch()) begin
      n_fail++;
      $display("FAIL %s: kicks sq=%b cq=%b tails=%h heads=%h, expected sq=%b cq=%b tails=%h heads=%h",
               tag, sq_kick, cq_kick, sq_tail_o, cq_head_o, eks, ekc, pack_st(), pack_ch());
    end
  endtask

  task automatic do_cfg(logic is_cq, int q, logic ex, int size, int bnd);
    @(negedge clk);
    cfg_en = 1'b1; cfg_is_cq = is_cq; cfg_qid = QW'(q); cfg_exists = ex;
    cfg_size = 16'(size); cfg_bind = QW'(bnd);
    @(negedge clk);
    cfg_en = 1'b0;
    if (is_cq) begin m_cx[q] = ex; m_cs[q] = size; m_ch[q] = 0; end
    else begin m_sx[q] = ex; m_ss[q] = size; m_sb[q] = bnd; m_st[q] = 0; end
  endtask

  task automatic do_write(int addr, logic [31:0] data, string tag);
    logic [NQ-1:0] eks = '0, ekc = '0;
    int kind = 0, q = 0, p;
    if (addr >= 4096 && addr % 4 == 0) begin
      if (((addr - 4096) / 4) % 2 == 1) begin kind = 2; q = (addr - 4100) / 8; end
      else begin kind = 1; q = (addr - 4096) / 8; end
    end
    p = int'(data & 32'hFFFF);
    if (kind == 1 && q < NQ && m_sx[q] && p < m_ss[q]) begin
      m_st[q] = p; eks[q] = 1'b1;
    end
    if (kind == 2 && q < NQ && m_cx[q] && p < m_cs[q]) begin
      if (model_full(q)) begin
        ekc[q] = 1'b1;
        for (int s = 0; s < NQ; s++) if (m_sx[s] && m_sb[s] == q) eks[s] = 1'b1;
      end
      m_ch[q] = p;
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'(addr); wr_data = data;
    @(posedge clk); #1;
    check_state(tag, eks, ekc);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1;
    check_state({tag, " R11 pulse end"}, '0, '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NQ; i++) begin
      m_sx[i] = 0; m_cx[i] = 0; m_ss[i] = 0; m_cs[i] = 0; m_sb[i] = 0;
      m_st[i] = 0; m_ch[i] = 0; m_ct[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 check_state("R11 reset state", '0, '0);
    @(negedge clk) rst_n = 1'b1;

    // Table: queues 0..5 exist, 6 and 7 do not
    for (int q = 0; q < 6; q++) begin
      do_cfg(1'b1, q, 1'b1, 4 + q, 0);
      do_cfg(1'b0, q, 1'b1, 4 + q, q % 3);
    end

    do_write('h1000, 32'd3, "R8 admin tail");
    do_write('h1004, 32'd2, "R3 R9 admin head");
    do_write('h1002, 32'd1, "R2 misaligned");
    do_write('h0FFC, 32'd1, "R1 below window");
    do_write('h1040, 32'd1, "R5 qid at count");
    do_write('h1044, 32'd1, "R5 head qid at count");
    do_write('h1030, 32'd1, "R6 missing sq");
    do_write('h1034, 32'd1, "R6 missing cq");
    do_write('h1008, 32'd5, "R7 ptr equals size");
    do_write('h1008, 32'hABCD_0004, "R4 upper bits");
    do_write('h1018, 32'd6, "R3 sq3 tail");

    // Full release on cq 2 (size 6): sq2 and sq5 bound to it
    m_ch[2] = m_ch[2];
    do_write('h1014, 32'd4, "R9 cq2 head");
    m_ct[2] = 16'd3;
    do_write('h1014, 32'd1, "R10 full release");
    do_write('h1014, 32'd2, "R9 non-full release");

    do_write('h1010, 32'd5, "R8 sq2 tail");
    do_cfg(1'b0, 2, 1'b1, 8, 2);
    #1 check_state("R12 reconfig clears tail", '0, '0);

    for (int it = 0; it < 400; it++) begin
      int q, addr;
      logic [31:0] d;
      q = int'($urandom % NQ);
      if (m_cx[q]) begin
        if ($urandom % 3 == 0) m_ct[q] = 16'((m_ch[q] + m_cs[q] - 1) % m_cs[q]);
        else m_ct[q] = 16'($urandom % m_cs[q]);
      end
      if ($urandom % 20 == 0)
        do_cfg(1'b0, int'($urandom % NQ), 1'($urandom % 4 != 0), 2 + int'($urandom % 8),
               int'($urandom % NQ));
      addr = 'h0FF0 + int'($urandom % (NQ * 8 + 32));
      if ($urandom % 4 != 0) addr = addr & ~3;
      d = ($urandom % 2 == 0) ? 32'($urandom % 10) : $urandom;
      do_write(addr, d, "R3 R8 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule